// File: doc/BRIEF.md
# Equal Digit Sum Search Engine

The engine scans a contiguous range of integers for values whose digit sum is the same in binary and in each of the odd prime bases 3, 5, 7, 11, 13 and 17. A host hands it one work package at a time: a first candidate, a number of candidates, and the digits of the first candidate in every odd base. The engine then visits one candidate per clock. Every value that passes the test is sent out on a valid/ready result stream, and a single-cycle completion pulse closes the package.

The engine does no division. Each base keeps its own digit register, which counts up by one with carry ripple, together with a running digit sum. The sum is updated from the number of trailing maximal digits that roll over on the step. A candidate is reported when all running sums are equal. The host does the one-time radix conversion of the starting value, which takes no time on the hardware side. The parameter `NUM_BASES` selects how many bases, taken in ascending order from the list, take part. The default uses all seven.

Top module: `dsum_search`

## Requirements
- R1: A candidate is a hit when its digit sum in each active base equals its binary digit sum (population count). The active bases are the first `NUM_BASES` of 2, 3, 5, 7, 11, 13, 17 in that order.
- R2: After reset `busy`, `done` and `res_valid` are low. A `start` sampled while idle loads `start_value`, `start_count` and `start_digits`. When the count is non-zero, `busy` is high from the following cycle. `start_digits` holds one slot per odd active base, in ascending base order from bit 0. Inside a slot the digits sit least significant first, one per 5-bit field. A slot has n fields, where n is the smallest value with base^n >= 2^W.
- R3: The candidates are visited in ascending order, from `start_value` to `start_value + start_count - 1`, one per clock while the stream is not stalled. The host keeps `start_value + start_count` at or below 2^W - 1. With `res_ready` held high, `done` is seen in the (count+2)-th cycle after the clock edge that samples `start`.
- R4: The values 0 and 1 are never reported, even when the range contains them.
- R5: While `res_valid` is high and `res_ready` is low, `res_valid` stays high, `res_value` holds, and the walk pauses. No hit is lost or reordered under any `res_ready` pattern.
- R6: `done` is high for exactly one cycle per package. It comes after the last result has been accepted, and `busy` is low in that cycle.
- R7: A package with a count of zero produces no result, never raises `busy`, and pulses `done` in the cycle after the `start` edge.
- R8: A `start` while `busy` is high is ignored. The running package finishes with its own results and timing, and it produces a single `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a package (honoured only while idle) |
| start_value | input | W | First candidate |
| start_count | input | CNT_W | Number of candidates |
| start_digits | input | DIG_BITS | Odd-base digits of the first candidate, packed as in R2 |
| busy | output | 1 | Package in progress |
| done | output | 1 | One-cycle completion pulse |
| res_valid | output | 1 | Result register holds a hit |
| res_ready | input | 1 | Consumer accepts the result |
| res_value | output | W | The reported candidate |

## Verification
The assertions assume that the host-supplied digits represent `start_value` exactly and that every digit is below its base. They also assume the range never wraps the binary counter. Under those conditions the running sums always equal the sums of the stored digits, and no counter overflows. The bench computes the digit slots itself by repeated division and keeps every range below 2^W - 1, including the one ending just short of the top. It runs a reduced base set so that hits are frequent enough to exercise the stall and ordering paths.

// File: rtl/dsum_pkg.sv
// Shared constants and elaboration-time helpers for the digit sum search engine.
// Assumes widths of at most 255 bits for the power computation.
package dsum_pkg;

    localparam int DIGIT_W   = 5;   // field width of one host-supplied digit
    localparam int MAX_BASES = 7;

    // Base used at position idx of the search set (ascending primes, binary first)
    function automatic int base_of(input int idx);
        case (idx)
            0:       return 2;
            1:       return 3;
            2:       return 5;
            3:       return 7;
            4:       return 11;
            5:       return 13;
            default: return 17;
        endcase
    endfunction

    // Smallest n with base**n >= 2**width
    function automatic int digits_for(input int base, input int width);
        logic [255:0] pw;
        logic [255:0] lim;
        pw  = 256'd1;
        lim = 256'd1 << width;
        for (int n = 0; n < 256; n++) begin
            if (pw >= lim) return n;
            pw = pw * 256'(base);
        end
        return width;
    endfunction

    // Bit offset of the slot for set position idx (idx >= 1) in the digit port
    function automatic int slot_offset(input int idx, input int width);
        int acc;
        acc = 0;
        for (int j = 1; j < idx; j++)
            acc += digits_for(base_of(j), width) * DIGIT_W;
        return acc;
    endfunction

    // Width needed for the largest digit sum over the first nbases bases
    function automatic int sum_width(input int nbases, input int width);
        int top;
        int cur;
        top = 1;
        for (int i = 0; i < nbases; i++) begin
            cur = digits_for(base_of(i), width) * (base_of(i) - 1);
            if (cur > top) top = cur;
        end
        return $clog2(top + 1);
    endfunction

endpackage

// File: rtl/dsum_radix_counter.sv
// Counter in a fixed radix that keeps its digits and a running digit sum.
// It loads a digit vector and steps by one with carry ripple. The sum is
// adjusted by the number of trailing maximal digits. Assumes the loaded digits
// are each below BASE and that the counter is never stepped from its top value.
module dsum_radix_counter #(
    parameter int BASE  = 3,
    parameter int NDIG  = 46,
    parameter int DW    = 5,
    parameter int SUM_W = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [NDIG*DW-1:0]   load_digits,
    input  logic                 step,
    output logic [SUM_W-1:0]     digit_sum
);

    localparam int             CW  = $clog2(NDIG + 1);
    localparam logic [DW-1:0]  TOP = DW'(BASE - 1);

    logic [NDIG*DW-1:0] digits_q;
    logic [NDIG*DW-1:0] digits_nxt;
    logic [CW-1:0]      trail;
    logic               at_top;
    logic [SUM_W-1:0]   sum_q;
    logic [SUM_W-1:0]   load_sum;

    // Ripple the +1 through the digits and count trailing maximal digits
    always_comb begin : carry_walk
        logic c;
        c          = 1'b1;
        trail      = '0;
        digits_nxt = digits_q;
        for (int i = 0; i < NDIG; i++) begin
            if (c) begin
                if (digits_q[i*DW +: DW] == TOP) begin
                    digits_nxt[i*DW +: DW] = '0;
                    trail                  = trail + CW'(1);
                end else begin
                    digits_nxt[i*DW +: DW] = digits_q[i*DW +: DW] + DW'(1);
                end
            end
            c = c && (digits_q[i*DW +: DW] == TOP);
        end
        at_top = c;
    end

    // Digit sum of the vector being loaded
    always_comb begin : load_sum_calc
        load_sum = '0;
        for (int i = 0; i < NDIG; i++)
            load_sum = load_sum + SUM_W'(load_digits[i*DW +: DW]);
    end

    // Register digits and running sum
    always_ff @(posedge clk) begin : state_reg
        if (!rst_n) begin
            digits_q <= '0;
            sum_q    <= '0;
        end else if (load) begin
            digits_q <= load_digits;
            sum_q    <= load_sum;
        end else if (step) begin
            digits_q <= digits_nxt;
            sum_q    <= sum_q + SUM_W'(1) - SUM_W'(int'(trail) * (BASE - 1));
        end
    end

    assign digit_sum = sum_q;

    // Checker: independent recount of the stored digits
    logic [SUM_W-1:0] recount;
    always_comb begin : recount_calc
        recount = '0;
        for (int i = 0; i < NDIG; i++)
            recount = recount + SUM_W'(digits_q[i*DW +: DW]);
    end

    assert_sum_matches_digits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sum_q == recount);

    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !at_top);

endmodule

// File: rtl/dsum_sequencer.sv
// Package control: accepts a start while idle, walks the candidate count while
// the output stage can take a new value, waits for the last result to drain,
// then pulses done. It also keeps the current candidate in binary form.
module dsum_sequencer #(
    parameter int W     = 72,
    parameter int CNT_W = 72
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     start_value,
    input  logic [CNT_W-1:0] start_count,
    input  logic             adv_ok,
    output logic             load,
    output logic             step,
    output logic [W-1:0]     cand,
    output logic             busy,
    output logic             done
);

    typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_FLUSH} sq_state_t;

    sq_state_t        state_q;
    logic [CNT_W-1:0] remaining_q;
    logic [W-1:0]     cand_q;
    logic             done_q;

    // Handshake decode: load only from idle, step only while running and unstalled
    always_comb begin : ctl_decode
        load = start && (state_q == SQ_IDLE);
        step = (state_q == SQ_RUN) && adv_ok;
    end

    // State, remaining count, candidate and completion pulse
    always_ff @(posedge clk) begin : seq_reg
        if (!rst_n) begin
            state_q     <= SQ_IDLE;
            remaining_q <= '0;
            cand_q      <= '0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        cand_q      <= start_value;
                        remaining_q <= start_count;
                        if (start_count == '0) done_q  <= 1'b1;
                        else                   state_q <= SQ_RUN;
                    end
                end
                SQ_RUN: begin
                    if (adv_ok) begin
                        cand_q      <= cand_q + W'(1);
                        remaining_q <= remaining_q - CNT_W'(1);
                        if (remaining_q == CNT_W'(1)) state_q <= SQ_FLUSH;
                    end
                end
                default: begin
                    if (adv_ok) begin
                        state_q <= SQ_IDLE;
                        done_q  <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign cand = cand_q;
    assign busy = (state_q != SQ_IDLE);
    assign done = done_q;

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state_q == SQ_IDLE));

    assert_idle_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_IDLE) |-> (remaining_q == '0));

    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q == SQ_RUN && !adv_ok) |=> $stable(remaining_q) && $stable(cand_q));

endmodule

// File: rtl/dsum_result_stage.sv
// Compares all running digit sums for the current candidate and captures a hit
// into a single valid/ready output register. A new value is accepted only when
// the register is empty or being drained (adv_ok). Assumes step implies adv_ok.
module dsum_result_stage #(
    parameter int W     = 72,
    parameter int NB    = 7,
    parameter int SUM_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NB*SUM_W-1:0] sums,
    input  logic [W-1:0]        cand,
    input  logic                step,
    input  logic                res_ready,
    output logic                adv_ok,
    output logic                res_valid,
    output logic [W-1:0]        res_value
);

    logic         hit;
    logic         valid_q;
    logic [W-1:0] value_q;

    // Equality of every base's sum with the binary sum, excluding 0 and 1
    always_comb begin : hit_detect
        hit = (cand > W'(1));
        for (int i = 1; i < NB; i++)
            if (sums[i*SUM_W +: SUM_W] != sums[0 +: SUM_W]) hit = 1'b0;
    end

    assign adv_ok = !valid_q || res_ready;

    // Output register with hold under back-pressure
    always_ff @(posedge clk) begin : out_reg
        if (!rst_n) begin
            valid_q <= 1'b0;
            value_q <= '0;
        end else if (step && hit) begin
            valid_q <= 1'b1;
            value_q <= cand;
        end else if (res_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign res_valid = valid_q;
    assign res_value = value_q;

    assert_hold_under_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !res_ready) |=> (valid_q && $stable(value_q)));

    assert_no_trivial_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (value_q > W'(1)));

endmodule

// File: rtl/dsum_search.sv
// Top of the digit sum search engine: one radix counter per active base, the
// package sequencer and the result stage. Assumes the host supplies the
// odd-base digits of start_value in the slot layout given by dsum_pkg.
module dsum_search
    import dsum_pkg::*;
#(
    parameter int W         = 72,
    parameter int CNT_W     = 72,
    parameter int NUM_BASES = 7,
    localparam int SUM_W    = sum_width(NUM_BASES, W),
    localparam int DIG_BITS = slot_offset(NUM_BASES, W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [W-1:0]        start_value,
    input  logic [CNT_W-1:0]    start_count,
    input  logic [DIG_BITS-1:0] start_digits,
    output logic                busy,
    output logic                done,
    output logic                res_valid,
    input  logic                res_ready,
    output logic [W-1:0]        res_value
);

    logic                       load;
    logic                       step;
    logic                       adv_ok;
    logic [W-1:0]               cand;
    logic [NUM_BASES*SUM_W-1:0] sums;

    dsum_sequencer #(.W(W), .CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_value (start_value),
        .start_count (start_count),
        .adv_ok      (adv_ok),
        .load        (load),
        .step        (step),
        .cand        (cand),
        .busy        (busy),
        .done        (done)
    );

    for (genvar b = 0; b < NUM_BASES; b++) begin : g_base
        localparam int BASE = base_of(b);
        if (b == 0) begin : g_bin
            dsum_radix_counter #(.BASE(2), .NDIG(W), .DW(1), .SUM_W(SUM_W)) u_cnt (
                .clk         (clk),
                .rst_n       (rst_n),
                .load        (load),
                .load_digits (start_value),
                .step        (step),
                .digit_sum   (sums[0 +: SUM_W])
            );
        end else begin : g_odd
            localparam int NDIG = digits_for(BASE, W);
            localparam int OFF  = slot_offset(b, W);
            dsum_radix_counter #(.BASE(BASE), .NDIG(NDIG), .DW(DIGIT_W), .SUM_W(SUM_W)) u_cnt (
                .clk         (clk),
                .rst_n       (rst_n),
                .load        (load),
                .load_digits (start_digits[OFF +: NDIG*DIGIT_W]),
                .step        (step),
                .digit_sum   (sums[b*SUM_W +: SUM_W])
            );
        end
    end

    dsum_result_stage #(.W(W), .NB(NUM_BASES), .SUM_W(SUM_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .sums      (sums),
        .cand      (cand),
        .step      (step),
        .res_ready (res_ready),
        .adv_ok    (adv_ok),
        .res_valid (res_valid),
        .res_value (res_value)
    );

    assert_reset_quiet_R2: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !res_valid));

endmodule

// File: tb/sim_dsum_search.sv
`timescale 1ns/1ps
module sim_dsum_search;

    localparam int W     = 72;
    localparam int CNT_W = 72;
    localparam int NB    = 3;
    localparam int DB    = dsum_pkg::slot_offset(NB, W);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  start_value = '0;
    logic [CNT_W-1:0] start_count = '0;
    logic [DB-1:0] start_digits = '0;
    logic          busy, done, res_valid;
    logic          res_ready = 1'b1;
    logic [W-1:0]  res_value;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    logic [W-1:0] got[$];

    always #2.5 clk = ~clk;

    dsum_search #(.W(W), .CNT_W(CNT_W), .NUM_BASES(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_value(start_value),
        .start_count(start_count), .start_digits(start_digits), .busy(busy),
        .done(done), .res_valid(res_valid), .res_ready(res_ready), .res_value(res_value)
    );

    // Handshake and completion monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && res_valid && res_ready) got.push_back(res_value);
        if (rst_n && done) done_cnt++;
    end

    function automatic int tb_base(input int i);
        return (i == 0) ? 2 : (i == 1) ? 3 : 5;
    endfunction

    function automatic int digsum(input logic [W-1:0] v, input int b);
        int s = 0;
        while (v != '0) begin
            s += int'(v % W'(b));
            v  = v / W'(b);
        end
        return s;
    endfunction

    function automatic bit is_hit(input logic [W-1:0] v);
        if (v < 2) return 1'b0;
        for (int i = 1; i < NB; i++)
            if (digsum(v, tb_base(i)) != digsum(v, 2)) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [DB-1:0] pack(input logic [W-1:0] v);
        logic [DB-1:0] r = '0;
        for (int s = 1; s < NB; s++) begin
            logic [W-1:0] t = v;
            int b   = tb_base(s);
            int off = dsum_pkg::slot_offset(s, W);
            int nd  = dsum_pkg::digits_for(b, W);
            for (int i = 0; i < nd; i++) begin
                r[off + i*5 +: 5] = 5'(t % W'(b));
                t = t / W'(b);
            end
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic launch(input logic [W-1:0] v, input logic [CNT_W-1:0] n);
        @(posedge clk); #1;
        start = 1'b1; start_value = v; start_count = n; start_digits = pack(v);
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    // Counts negedges after the start edge until done; records busy at the first one
    task automatic wait_done(output int cyc, output logic busy_first);
        cyc = 0;
        busy_first = 1'b0;
        while (cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) busy_first = busy;
            if (done) break;
        end
    endtask

    task automatic cmp_list(input string req, input logic [W-1:0] v0, input int n);
        logic [W-1:0] exp[$];
        for (int k = 0; k < n; k++) if (is_hit(v0 + W'(k))) exp.push_back(v0 + W'(k));
        chk(got.size() == exp.size(), req, W'(got.size()), W'(exp.size()));
        for (int i = 0; i < exp.size() && i < got.size(); i++)
            chk(got[i] == exp[i], req, got[i], exp[i]);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy == 1'b0, "R2 reset busy", W'(busy), 0);
        chk(done == 1'b0, "R2 reset done", W'(done), 0);
        chk(res_valid == 1'b0, "R2 reset valid", W'(res_valid), 0);
    endtask

    task automatic t_basic();
        int cyc; logic bf;
        got.delete(); done_cnt = 0;
        launch('0, 40);
        wait_done(cyc, bf);
        chk(bf == 1'b1, "R2 busy after start", W'(bf), 1);
        chk(cyc == 42, "R3 done timing", W'(cyc), 42);
        chk(busy == 1'b0, "R6 busy low with done", W'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R6 done one cycle", W'(done), 0);
        cmp_list("R1 R3 hit list", '0, 40);
        for (int i = 0; i < got.size(); i++)
            chk(got[i] > 1, "R4 no trivial value", got[i], 2);
    endtask

    task automatic t_stall();
        int cyc = 0; logic [W-1:0] held; logic [W-1:0] first = '0; bit fin = 0;
        for (int k = 2; k < 62; k++) if (is_hit(W'(k)) && first == '0) first = W'(k);
        got.delete(); done_cnt = 0;
        res_ready = 1'b0;
        launch(2, 60);
        repeat (10) @(negedge clk);
        chk(res_valid == 1'b1, "R5 valid held", W'(res_valid), 1);
        chk(res_value == first, "R5 first hit", res_value, first);
        held = res_value;
        repeat (15) @(negedge clk);
        chk(res_value == held && res_valid, "R5 value stable", res_value, held);
        chk(busy == 1'b1, "R5 walk paused", W'(busy), 1);
        while (!fin && cyc < 2000) begin
            @(posedge clk); #1 res_ready = ~res_ready;
            @(negedge clk); cyc++;
            if (done) fin = 1;
        end
        res_ready = 1'b1;
        @(negedge clk);
        cmp_list("R5 no hit lost", 2, 60);
        chk(done_cnt == 1, "R6 single done", W'(done_cnt), 1);
    endtask

    task automatic t_zero();
        int cyc; logic bf;
        got.delete(); done_cnt = 0;
        launch(5, 0);
        wait_done(cyc, bf);
        chk(cyc == 1, "R7 zero count done", W'(cyc), 1);
        chk(bf == 1'b0, "R7 busy stays low", W'(bf), 0);
        repeat (3) @(negedge clk);
        chk(got.size() == 0, "R7 no result", W'(got.size()), 0);
    endtask

    task automatic t_busy_start();
        int cyc; logic bf;
        got.delete(); done_cnt = 0;
        launch(100, 30);
        fork
            begin
                repeat (5) @(posedge clk);
                #1 start = 1'b1; start_value = 7; start_count = 3; start_digits = pack(7);
                @(posedge clk); #1 start = 1'b0;
            end
        join_none
        wait_done(cyc, bf);
        chk(cyc == 32, "R8 timing unchanged", W'(cyc), 32);
        repeat (4) @(negedge clk);
        chk(done_cnt == 1, "R8 single done", W'(done_cnt), 1);
        cmp_list("R8 original list", 100, 30);
    endtask

    task automatic t_high();
        int cyc; logic bf;
        logic [W-1:0] v0 = {W{1'b1}} - W'(39);
        got.delete(); done_cnt = 0;
        launch(v0, 38);
        wait_done(cyc, bf);
        chk(cyc == 40, "R3 high range timing", W'(cyc), 40);
        cmp_list("R1 high range list", v0, 38);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_stall();
        t_zero();
        t_busy_start();
        t_high();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule